// File: doc/BRIEF.md
# Multi-Bank Precharge State Tracker

This block lives on the controller side of a DRAM command path and keeps a record of which of its banks hold an open row and which are idle. Each cycle it may receive one decoded command (activate, read, write or precharge) together with a bank number and an all-banks flag taken from row address bit 8. A precharge closes either the one addressed bank or every bank, depending on that flag, and then holds the affected banks back from reactivation for a recovery window of `TRP_CYC` clock cycles, counted by a down-counter per bank.

The tracker publishes, per bank, whether a row is open and whether the bank may accept an activate now. It also gives a registered any-bank-open summary and a one-cycle illegal-command pulse for accesses that break the bank protocol. An illegal activate changes nothing in the tracked state. The scheduler upstream uses the ready vector to pick banks and the illegal pulse as an error indicator.

Top module: `bank_state_tracker`

## Requirements
- R1: A valid precharge (`cmd_code` = 4) with `cmd_all` = 1 closes every bank on the next cycle whatever value `cmd_bank` holds, and starts the recovery counter of every bank.
- R2: A valid precharge with `cmd_all` = 0 closes only the bank numbered `cmd_bank` (bit `cmd_bank` of the status vectors); the open state of all other banks is unchanged.
- R3: After a precharge on the clock edge at cycle k, that bank's `bank_ready` bit stays low and reads high from cycle k + `TRP_CYC` onward, so an activate is accepted no earlier than `TRP_CYC` edges after the precharge.
- R4: A valid read (`cmd_code` = 2) or write (`cmd_code` = 3) to an idle bank raises `illegal_cmd`; to an open bank it raises nothing and leaves the bank state unchanged.
- R5: A valid activate (`cmd_code` = 1) to a ready bank sets its `bank_open` bit on the next cycle; `bank_ready` is low for every bank whose row is open.
- R6: An activate to a bank that is already open, or whose recovery counter is still running, raises `illegal_cmd` and leaves `bank_open` and `bank_ready` unchanged.
- R7: A precharge to a bank that is already idle is legal (no `illegal_cmd`) and restarts its recovery counter at the full `TRP_CYC`.
- R8: `any_open` is registered and equals the OR of `bank_open` in every cycle.
- R9: While reset is applied and after its release, all banks read idle and ready, `any_open` is 0 and `illegal_cmd` is 0.
- R10: `illegal_cmd` is a single-cycle pulse per offending command; a cycle with `cmd_valid` low, or with a reserved code (5 to 7), changes no state and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5-7 reserved |
| cmd_bank | input | BA_W (3) | Target bank number |
| cmd_all | input | 1 | Row address bit 8: precharge all banks when high |
| bank_open | output | NUM_BANKS (8) | Per-bank row-open status |
| bank_ready | output | NUM_BANKS (8) | Per-bank: idle and recovery window over |
| any_open | output | 1 | Registered OR of all open bits |
| illegal_cmd | output | 1 | One-cycle pulse for a protocol violation |

## Verification
The assertions take for granted that `cmd_code`, `cmd_bank` and `cmd_all` carry known values whenever `cmd_valid` is high and that no command arrives in the two cycles while the internal reset is still being released, since commands there would be dropped without being seen by the properties' reset guard. The bench holds `cmd_valid` low through reset and for several cycles after it, drives only defined values, and changes inputs on the falling clock edge so every command is captured cleanly by exactly one rising edge.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  localparam int unsigned CODE_W = 3;

endpackage

// File: rtl/bank_trk_rst_sync.sv
module bank_trk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bank_trk_decode.sv
module bank_trk_decode
  import bank_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BA_W      = 3
) (
  input  logic                 cmd_valid,
  input  cmd_e                 cmd_code,
  input  logic [BA_W-1:0]      cmd_bank,
  input  logic                 cmd_all,
  output logic [NUM_BANKS-1:0] act_hit,
  output logic [NUM_BANKS-1:0] pre_hit,
  output logic [NUM_BANKS-1:0] rw_hit
);

  logic is_act;
  logic is_pre;
  logic is_rw;

  always_comb begin
    is_act = cmd_valid && (cmd_code == CMD_ACT);
    is_pre = cmd_valid && (cmd_code == CMD_PRE);
    is_rw  = cmd_valid && ((cmd_code == CMD_RD) || (cmd_code == CMD_WR));
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
    logic addr_match;
    assign addr_match = (cmd_bank == BA_W'(g));
    assign act_hit[g] = is_act && addr_match;
    assign rw_hit[g]  = is_rw && addr_match;
    assign pre_hit[g] = is_pre && (cmd_all || addr_match);
  end

endmodule

// File: rtl/bank_trk_slot.sv
module bank_trk_slot #(
  parameter int unsigned TRP_CYC = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_hit,
  input  logic pre_hit,
  output logic open_q,
  output logic open_nxt,
  output logic ready
);

  localparam logic [CNT_W-1:0] TRP_LOAD = CNT_W'(TRP_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic             cnt_busy;
  logic             act_take;

  always_comb begin
    cnt_busy = (cnt_q != '0);
    ready    = !open_q && !cnt_busy;
    act_take = act_hit && ready;

    if (pre_hit) begin
      open_nxt = 1'b0;
    end else if (act_take) begin
      open_nxt = 1'b1;
    end else begin
      open_nxt = open_q;
    end

    cnt_en = pre_hit || cnt_busy;
    if (pre_hit) begin
      cnt_nxt = TRP_LOAD;
    end else begin
      cnt_nxt = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else begin
      open_q <= open_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
  import bank_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned TRP_CYC   = 4,
  parameter int unsigned BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_code,
  input  logic [BA_W-1:0]      cmd_bank,
  input  logic                 cmd_all,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] bank_ready,
  output logic                 any_open,
  output logic                 illegal_cmd
);

  localparam int unsigned CNT_W = $clog2(TRP_CYC + 1);

  logic                 rst_int_n;
  cmd_e                 code_dec;
  logic [NUM_BANKS-1:0] act_hit;
  logic [NUM_BANKS-1:0] pre_hit;
  logic [NUM_BANKS-1:0] rw_hit;
  logic [NUM_BANKS-1:0] open_nxt;
  logic                 illegal_nxt;
  logic                 any_nxt;
  logic                 illegal_q;
  logic                 any_q;

  bank_trk_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign code_dec = cmd_e'(cmd_code);

  bank_trk_decode #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
  ) decode_i (
    .cmd_valid (cmd_valid),
    .cmd_code  (code_dec),
    .cmd_bank  (cmd_bank),
    .cmd_all   (cmd_all),
    .act_hit   (act_hit),
    .pre_hit   (pre_hit),
    .rw_hit    (rw_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_trk_slot #(
      .TRP_CYC (TRP_CYC),
      .CNT_W   (CNT_W)
    ) slot_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .act_hit  (act_hit[b]),
      .pre_hit  (pre_hit[b]),
      .open_q   (bank_open[b]),
      .open_nxt (open_nxt[b]),
      .ready    (bank_ready[b])
    );
  end

  always_comb begin
    illegal_nxt = (|(act_hit & ~bank_ready)) || (|(rw_hit & ~bank_open));
    any_nxt     = |open_nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      illegal_q <= 1'b0;
      any_q     <= 1'b0;
    end else begin
      illegal_q <= illegal_nxt;
      any_q     <= any_nxt;
    end
  end

  assign illegal_cmd = illegal_q;
  assign any_open    = any_q;

endmodule

// File: rtl/bank_state_tracker_chk.sv
module bank_state_tracker_chk #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BA_W      = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_code,
  input logic [BA_W-1:0]      cmd_bank,
  input logic                 cmd_all,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [NUM_BANKS-1:0] bank_ready,
  input logic                 any_open,
  input logic                 illegal_cmd
);

  localparam logic [NUM_BANKS-1:0] ONE = NUM_BANKS'(1);

  logic is_act, is_pre, is_rw;
  assign is_act = cmd_valid && (cmd_code == 3'd1);
  assign is_rw  = cmd_valid && ((cmd_code == 3'd2) || (cmd_code == 3'd3));
  assign is_pre = cmd_valid && (cmd_code == 3'd4);

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && cmd_all) |=> (bank_open == '0) && (bank_ready == '0)); // R1

  AST_PRE_ONE_SPARES_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && !cmd_all) |=> !bank_open[$past(cmd_bank)] &&
      ((bank_open & ~(ONE << $past(cmd_bank))) == $past(bank_open & ~(ONE << cmd_bank)))); // R2

  AST_PRE_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && !cmd_all) |=> !bank_ready[$past(cmd_bank)]); // R3

  AST_RW_IDLE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && !bank_open[cmd_bank]) |=> illegal_cmd); // R4

  AST_RW_OPEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && bank_open[cmd_bank]) |=> !illegal_cmd && $stable(bank_open)); // R4

  AST_OPEN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_open & bank_ready) == '0); // R5

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && bank_ready[cmd_bank]) |=> bank_open[$past(cmd_bank)] && !illegal_cmd); // R5

  AST_ACT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && !bank_ready[cmd_bank]) |=> illegal_cmd && $stable(bank_open)); // R6

  AST_ANY_OPEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    any_open == (|bank_open)); // R8

  AST_IDLE_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_act || is_rw || is_pre) |=> !illegal_cmd && $stable(bank_open)); // R10

endmodule

bind bank_state_tracker bank_state_tracker_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BA_W      (BA_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .cmd_bank    (cmd_bank),
  .cmd_all     (cmd_all),
  .bank_open   (bank_open),
  .bank_ready  (bank_ready),
  .any_open    (any_open),
  .illegal_cmd (illegal_cmd)
);

// File: tb/bank_state_tracker_tb_top.sv
module bank_state_tracker_tb_top;

  localparam int unsigned NB  = 8;
  localparam int unsigned TRP = 4;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_code;
  logic [2:0]    cmd_bank;
  logic          cmd_all;
  logic [NB-1:0] bank_open;
  logic [NB-1:0] bank_ready;
  logic          any_open;
  logic          illegal_cmd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  bank_state_tracker #(.NUM_BANKS(NB), .TRP_CYC(TRP)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_bank    (cmd_bank),
    .cmd_all     (cmd_all),
    .bank_open   (bank_open),
    .bank_ready  (bank_ready),
    .any_open    (any_open),
    .illegal_cmd (illegal_cmd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Present one command for exactly one rising edge; returns at the next
  // falling edge, when outputs reflect that command.
  task automatic issue(input logic [2:0] c, input logic [2:0] b, input logic a);
    cmd_valid = 1'b1; cmd_code = c; cmd_bank = b; cmd_all = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 3'd0; cmd_bank = 3'd0; cmd_all = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 open",    bank_open,   '0);
    chk("R9 ready",   bank_ready,  8'hFF);
    chk("R9 any",     any_open,    0);
    chk("R9 illegal", illegal_cmd, 0);
  endtask

  task automatic t_activate_rw();
    issue(3'd1, 3'd2, 1'b0);
    chk("R5 open after act",   bank_open,   8'h04);
    chk("R5 ready while open", bank_ready,  8'hFB);
    chk("R8 any after act",    any_open,    1);
    chk("R5 act legal",        illegal_cmd, 0);
    issue(3'd2, 3'd2, 1'b0);
    chk("R4 read open legal",  illegal_cmd, 0);
    chk("R4 read keeps state", bank_open,   8'h04);
    issue(3'd3, 3'd5, 1'b0);
    chk("R4 write idle flagged", illegal_cmd, 1);
    issue(3'd1, 3'd2, 1'b0);
    chk("R6 act open flagged", illegal_cmd, 1);
    chk("R6 act open no change", bank_open, 8'h04);
    chk("R6 ready unchanged",  bank_ready,  8'hFB);
    idle(1);
    chk("R10 pulse one cycle", illegal_cmd, 0);
  endtask

  task automatic t_single_pre_trp();
    issue(3'd1, 3'd1, 1'b0);
    issue(3'd1, 3'd6, 1'b0);
    chk("R5 three open", bank_open, 8'h46);
    issue(3'd4, 3'd1, 1'b0);
    chk("R2 only bank1 closed", bank_open, 8'h44);
    chk("R2 pre legal",         illegal_cmd, 0);
    chk("R3 bank1 blocked",     bank_ready[1], 0);
    issue(3'd1, 3'd1, 1'b0);
    chk("R6 act during trp flagged", illegal_cmd, 1);
    chk("R6 act during trp no open", bank_open, 8'h44);
    idle(2);
    chk("R3 bank1 still blocked", bank_ready[1], 0);
    idle(1);
    chk("R3 bank1 ready at trp", bank_ready[1], 1);
    issue(3'd1, 3'd1, 1'b0);
    chk("R3 act after trp opens", bank_open, 8'h46);
    chk("R3 act after trp legal", illegal_cmd, 0);
  endtask

  task automatic t_pre_all();
    issue(3'd4, 3'd3, 1'b1);
    chk("R1 all closed",   bank_open,  '0);
    chk("R1 none ready",   bank_ready, '0);
    chk("R8 any cleared",  any_open,   0);
    idle(3);
    chk("R1 all still blocked", bank_ready, '0);
    idle(1);
    chk("R1 all ready after trp", bank_ready, 8'hFF);
  endtask

  task automatic t_pre_idle();
    issue(3'd4, 3'd7, 1'b0);
    chk("R7 pre idle legal",   illegal_cmd, 0);
    chk("R7 bank7 blocked",    bank_ready,  8'h7F);
    idle(2);
    issue(3'd4, 3'd7, 1'b0);
    idle(3);
    chk("R7 restart holds bank7", bank_ready[7], 0);
    idle(1);
    chk("R7 bank7 ready after restart", bank_ready[7], 1);
  endtask

  task automatic t_no_effect();
    issue(3'd1, 3'd0, 1'b0);
    chk("R5 bank0 open", bank_open, 8'h01);
    cmd_valid = 1'b0; cmd_code = 3'd1; cmd_bank = 3'd3;
    @(negedge clk);
    cmd_code = 3'd0; cmd_bank = 3'd0;
    chk("R10 invalid act ignored", bank_open,   8'h01);
    chk("R10 invalid no pulse",    illegal_cmd, 0);
    issue(3'd5, 3'd0, 1'b1);
    chk("R10 reserved code no change", bank_open,   8'h01);
    chk("R10 reserved code no pulse",  illegal_cmd, 0);
    chk("R8 any with bank0",           any_open,    1);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 3'd0; cmd_bank = 3'd0; cmd_all = 1'b0;
    idle(3);
    chk("R9 open in reset", bank_open, '0);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_activate_rw();
    t_single_pre_trp();
    t_pre_all();
    t_pre_idle();
    t_no_effect();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule